// File: doc/BRIEF.md
# Register Alias Table with Free Physical Register Pool

This block holds the speculative mapping from architectural register indices to physical register indices for a rename stage that handles several instructions per cycle. It keeps a pool of unused physical registers and one ready bit per physical register. In each cycle the rename stage presents its source operands for lookup and its destination operands for allocation. One cycle later the block returns, for every source, the physical register and whether its value already exists. For every destination it returns a fresh physical register together with the one it displaced.

Squash recovery uses two paths. A restore port writes an older physical register back into one architectural entry. Return ports give physical registers back to the pool; the commit side also uses them to free displaced registers. A writeback port marks produced registers ready. The free count is visible at all times, so the rename stage can stall before it asks for more destinations than the pool holds.

Top module: `rat_freelist`

## Requirements
- R1: One cycle after synchronous reset is released, architectural index i maps to physical register i and that register reads as ready. `free_count` equals PHYS_REGS minus ARCH_REGS, and the pool hands out the registers ARCH_REGS, ARCH_REGS+1, ... in ascending order.
- R2: A source index presented in cycle t returns its physical register on `src_phys` in cycle t+1, in the slot of the same index (slot s occupies bits [s*PW +: PW]).
- R3: `src_ready` in cycle t+1 is the ready bit of the looked-up register as held in cycle t. A writeback to that register in cycle t also makes it read as ready.
- R4: Each granted destination lane k returns, in cycle t+1, `ren_valid[k]`=1 together with a new register (`ren_new`) taken from the head of the pool and the previous mapping (`ren_old`). Lanes draw from the pool in ascending lane order.
- R5: When two lanes of one cycle rename the same architectural index, the higher lane reports the lower lane's new register as its previous mapping, and the higher lane's register becomes the mapping.
- R6: A lookup in the same cycle as a rename of that index returns the mapping from before the rename.
- R7: If the number of requesting lanes exceeds `free_count`, no lane is granted. `ren_valid` stays 0 and neither the mapping nor the pool changes.
- R8: `restore_en` writes `restore_phys` into the entry `restore_arch`. While it is high, no rename request is granted.
- R9: Registers on the return lanes join the tail of the pool in ascending lane order. They can be allocated from the next cycle onward, after all registers already in the pool.
- R10: Allocating a register clears its ready bit, and this wins over a writeback to that register in the same cycle. A later writeback sets it again.
- R11: `free_count` in cycle t+1 equals its value in cycle t, minus the granted lanes, plus the returned registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_arch | input | NSRC*AW | Architectural indices to look up, one slot per source |
| src_phys | output | NSRC*PW | Mapped physical registers, one cycle later |
| src_ready | output | NSRC | Ready flag of each looked-up register, one cycle later |
| ren_req | input | LANES | Destination rename request per lane |
| ren_arch | input | LANES*AW | Destination architectural index per lane |
| ren_valid | output | LANES | Lane was granted (registered) |
| ren_new | output | LANES*PW | Newly allocated physical register per lane |
| ren_old | output | LANES*PW | Previous physical mapping per lane |
| restore_en | input | 1 | Restore one mapping entry this cycle |
| restore_arch | input | AW | Entry to restore |
| restore_phys | input | PW | Physical register to write back |
| ret_en | input | LANES | Return a physical register to the pool, per lane |
| ret_phys | input | LANES*PW | Returned physical register per lane |
| wb_en | input | LANES | Writeback marks a register ready, per lane |
| wb_phys | input | LANES*PW | Physical register written back per lane |
| free_count | output | CW | Registers currently in the pool |

## Verification
The hardest state to reach from the ports is an empty or nearly empty pool while a two-lane request arrives. Only there does the all-or-nothing refusal differ from partial allocation, and only there do the pool pointers wrap. The stimulus renames without returning until fewer than two registers remain, then requests both lanes. After that it drains its list of displaced registers back through the return lanes during a long random phase, so the pool pointers wrap many times. Same-cycle conflicts are also set up on purpose: both lanes on one index with a lookup of it, a writeback racing a lookup, and a restore paired with a return.

// File: rtl/rat_pkg.sv
package rat_pkg;

  // Advance a circular index by step within a ring of the given depth.
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned depth);
    return (base + step) % depth;
  endfunction

endpackage

// File: rtl/rat_free_fifo.sv
module rat_free_fifo
  import rat_pkg::*;
#(
  parameter int PHYS_REGS = 16,
  parameter int ARCH_REGS = 8,
  parameter int LANES     = 2,
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LW-1:0]       pop_num,
  input  logic [LANES-1:0]    push_en,
  input  logic [LANES*PW-1:0] push_phys,
  output logic [LANES*PW-1:0] peek_phys,
  output logic [CW-1:0]       count
);

  logic [PW-1:0]   slot_q [DEPTH];
  logic [PTRW-1:0] head_q;
  logic [PTRW-1:0] tail_q;
  logic [CW-1:0]   count_q;
  logic [LW-1:0]   push_num;
  logic [LW-1:0]   push_ofs [LANES];

  // Compact the push lanes so they land in consecutive slots.
  always_comb begin
    push_num = '0;
    for (int k = 0; k < LANES; k++) begin
      push_ofs[k] = push_num;
      push_num    = push_num + LW'(push_en[k]);
    end
  end

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_peek
      assign peek_phys[j*PW +: PW] =
        slot_q[PTRW'(ring_add(32'(head_q), j, DEPTH))];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_q[i] <= PW'(ARCH_REGS + i);
      end
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (push_en[k]) begin
          slot_q[PTRW'(ring_add(32'(tail_q), 32'(push_ofs[k]), DEPTH))] <=
            push_phys[k*PW +: PW];
        end
      end
      head_q  <= PTRW'(ring_add(32'(head_q), 32'(pop_num), DEPTH));
      tail_q  <= PTRW'(ring_add(32'(tail_q), 32'(push_num), DEPTH));
      count_q <= count_q - CW'(pop_num) + CW'(push_num);
    end
  end

  assign count = count_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(pop_num) <= 32'(count_q)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (32'(count_q) - 32'(pop_num) + 32'(push_num)) <= DEPTH); // R9

endmodule

// File: rtl/rat_map_table.sv
module rat_map_table #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int LANES     = 2,
  parameter int NSRC      = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC*AW-1:0]  lk_arch,
  output logic [NSRC*PW-1:0]  lk_phys_now,
  output logic [NSRC*PW-1:0]  lk_phys_q,
  input  logic [LANES-1:0]    alloc_en,
  input  logic [LANES*AW-1:0] alloc_arch,
  input  logic [LANES*PW-1:0] alloc_phys,
  output logic [LANES*PW-1:0] prev_phys,
  input  logic                restore_en,
  input  logic [AW-1:0]       restore_arch,
  input  logic [PW-1:0]       restore_phys
);

  logic [PW-1:0] map_q [ARCH_REGS];

  // Lookups read the table as it stands before this cycle's writes.
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_lk
      assign lk_phys_now[s*PW +: PW] = map_q[lk_arch[s*AW +: AW]];
    end
  endgenerate

  // Previous mapping per lane, forwarded from lower lanes of this cycle.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      prev_phys[k*PW +: PW] = map_q[alloc_arch[k*AW +: AW]];
      for (int j = 0; j < k; j++) begin
        if (alloc_en[j] && (alloc_arch[j*AW +: AW] == alloc_arch[k*AW +: AW])) begin
          prev_phys[k*PW +: PW] = alloc_phys[j*PW +: PW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i] <= PW'(i);
      end
      lk_phys_q <= '0;
    end else begin
      lk_phys_q <= lk_phys_now;
      if (restore_en) begin
        map_q[restore_arch] <= restore_phys;
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (alloc_en[k]) begin
            map_q[alloc_arch[k*AW +: AW]] <= alloc_phys[k*PW +: PW];
          end
        end
      end
    end
  end

endmodule

// File: rtl/rat_ready_bits.sv
module rat_ready_bits #(
  parameter int PHYS_REGS = 16,
  parameter int LANES     = 2,
  parameter int NSRC      = 4,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC*PW-1:0]  lk_phys,
  output logic [NSRC-1:0]     lk_ready_q,
  input  logic [LANES-1:0]    wb_en,
  input  logic [LANES*PW-1:0] wb_phys,
  input  logic [LANES-1:0]    alloc_en,
  input  logic [LANES*PW-1:0] alloc_phys
);

  logic [PHYS_REGS-1:0] ready_q;
  logic [PHYS_REGS-1:0] ready_d;
  logic [NSRC-1:0]      lk_ready_d;

  // Writeback sets, allocation clears; allocation is applied last.
  always_comb begin
    ready_d = ready_q;
    for (int k = 0; k < LANES; k++) begin
      if (wb_en[k]) ready_d[wb_phys[k*PW +: PW]] = 1'b1;
    end
    for (int k = 0; k < LANES; k++) begin
      if (alloc_en[k]) ready_d[alloc_phys[k*PW +: PW]] = 1'b0;
    end
  end

  // A lookup also sees a writeback that lands in the same cycle.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      lk_ready_d[s] = ready_q[lk_phys[s*PW +: PW]];
      for (int k = 0; k < LANES; k++) begin
        if (wb_en[k] && (wb_phys[k*PW +: PW] == lk_phys[s*PW +: PW])) begin
          lk_ready_d[s] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= '1;
      lk_ready_q <= '0;
    end else begin
      ready_q    <= ready_d;
      lk_ready_q <= lk_ready_d;
    end
  end

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_chk
      AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        alloc_en[k] |=> (ready_q[$past(alloc_phys[k*PW +: PW])] == 1'b0)); // R10
    end
  endgenerate

endmodule

// File: rtl/rat_freelist.sv
module rat_freelist #(
  parameter int ARCH_REGS    = 8,
  parameter int PHYS_REGS    = 16,
  parameter int LANES        = 2,
  parameter int SRC_PER_LANE = 2,
  localparam int NSRC  = LANES * SRC_PER_LANE,
  localparam int AW    = $clog2(ARCH_REGS),
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS - ARCH_REGS,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC*AW-1:0]  src_arch,
  output logic [NSRC*PW-1:0]  src_phys,
  output logic [NSRC-1:0]     src_ready,
  input  logic [LANES-1:0]    ren_req,
  input  logic [LANES*AW-1:0] ren_arch,
  output logic [LANES-1:0]    ren_valid,
  output logic [LANES*PW-1:0] ren_new,
  output logic [LANES*PW-1:0] ren_old,
  input  logic                restore_en,
  input  logic [AW-1:0]       restore_arch,
  input  logic [PW-1:0]       restore_phys,
  input  logic [LANES-1:0]    ret_en,
  input  logic [LANES*PW-1:0] ret_phys,
  input  logic [LANES-1:0]    wb_en,
  input  logic [LANES*PW-1:0] wb_phys,
  output logic [CW-1:0]       free_count
);

  logic [LW-1:0]       n_req;
  logic [LW-1:0]       req_ofs [LANES];
  logic                grant;
  logic [LANES-1:0]    alloc_en;
  logic [LANES*PW-1:0] alloc_phys;
  logic [LANES*PW-1:0] peek_phys;
  logic [LANES*PW-1:0] prev_phys;
  logic [NSRC*PW-1:0]  lk_phys_now;
  logic [CW-1:0]       pool_cnt;
  logic [LANES-1:0]    ren_valid_q;
  logic [LANES*PW-1:0] ren_new_q;
  logic [LANES*PW-1:0] ren_old_q;

  always_comb begin
    n_req = '0;
    for (int k = 0; k < LANES; k++) begin
      req_ofs[k] = n_req;
      n_req      = n_req + LW'(ren_req[k]);
    end
  end

  // All requesting lanes are granted together or none is.
  assign grant    = !restore_en && (32'(n_req) <= 32'(pool_cnt));
  assign alloc_en = grant ? ren_req : '0;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_pick
      assign alloc_phys[k*PW +: PW] = peek_phys[32'(req_ofs[k])*PW +: PW];
    end
  endgenerate

  rat_free_fifo #(
    .PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS), .LANES(LANES)
  ) u_pool (
    .clk       (clk),
    .rst       (rst),
    .pop_num   (grant ? n_req : '0),
    .push_en   (ret_en),
    .push_phys (ret_phys),
    .peek_phys (peek_phys),
    .count     (pool_cnt)
  );

  rat_map_table #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .LANES(LANES), .NSRC(NSRC)
  ) u_map (
    .clk          (clk),
    .rst          (rst),
    .lk_arch      (src_arch),
    .lk_phys_now  (lk_phys_now),
    .lk_phys_q    (src_phys),
    .alloc_en     (alloc_en),
    .alloc_arch   (ren_arch),
    .alloc_phys   (alloc_phys),
    .prev_phys    (prev_phys),
    .restore_en   (restore_en),
    .restore_arch (restore_arch),
    .restore_phys (restore_phys)
  );

  rat_ready_bits #(
    .PHYS_REGS(PHYS_REGS), .LANES(LANES), .NSRC(NSRC)
  ) u_ready (
    .clk        (clk),
    .rst        (rst),
    .lk_phys    (lk_phys_now),
    .lk_ready_q (src_ready),
    .wb_en      (wb_en),
    .wb_phys    (wb_phys),
    .alloc_en   (alloc_en),
    .alloc_phys (alloc_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_valid_q <= '0;
      ren_new_q   <= '0;
      ren_old_q   <= '0;
    end else begin
      ren_valid_q <= alloc_en;
      ren_new_q   <= alloc_phys;
      ren_old_q   <= prev_phys;
    end
  end

  assign ren_valid  = ren_valid_q;
  assign ren_new    = ren_new_q;
  assign ren_old    = ren_old_q;
  assign free_count = pool_cnt;

  AST_RESTORE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> (ren_valid == '0)); // R8

  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (rst)
    $countones(ren_valid) <= 32'($past(free_count))); // R7

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_pair
      AST_PAIR_DIFFERS: assert property (@(posedge clk) disable iff (rst)
        ren_valid[k] |-> (ren_new[k*PW +: PW] != ren_old[k*PW +: PW])); // R4
    end
  endgenerate

endmodule

// File: tb/rat_freelist_tb.sv
module rat_freelist_tb;

  localparam int ARCH  = 8;
  localparam int PHYS  = 16;
  localparam int L     = 2;
  localparam int NSRC  = 4;
  localparam int AW    = 3;
  localparam int PW    = 4;
  localparam int CW    = 4;
  localparam int DEPTH = PHYS - ARCH;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC*AW-1:0] src_arch = '0;
  logic [NSRC*PW-1:0] src_phys;
  logic [NSRC-1:0]    src_ready;
  logic [L-1:0]       ren_req = '0;
  logic [L*AW-1:0]    ren_arch = '0;
  logic [L-1:0]       ren_valid;
  logic [L*PW-1:0]    ren_new;
  logic [L*PW-1:0]    ren_old;
  logic               restore_en = 1'b0;
  logic [AW-1:0]      restore_arch = '0;
  logic [PW-1:0]      restore_phys = '0;
  logic [L-1:0]       ret_en = '0;
  logic [L*PW-1:0]    ret_phys = '0;
  logic [L-1:0]       wb_en = '0;
  logic [L*PW-1:0]    wb_phys = '0;
  logic [CW-1:0]      free_count;

  always #10 clk = ~clk;  // 50 MHz

  rat_freelist #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .LANES(L), .SRC_PER_LANE(2)) u_dut (
    .clk(clk), .rst(rst), .src_arch(src_arch), .src_phys(src_phys), .src_ready(src_ready),
    .ren_req(ren_req), .ren_arch(ren_arch), .ren_valid(ren_valid), .ren_new(ren_new),
    .ren_old(ren_old), .restore_en(restore_en), .restore_arch(restore_arch),
    .restore_phys(restore_phys), .ret_en(ret_en), .ret_phys(ret_phys), .wb_en(wb_en),
    .wb_phys(wb_phys), .free_count(free_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  int m_map [ARCH];
  bit m_rdy [PHYS];
  int m_free [$];
  int m_pend [$];
  string force_tag = "";

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_free.delete();
    m_pend.delete();
    for (int i = 0; i < ARCH; i++) m_map[i] = i;
    for (int i = 0; i < PHYS; i++) m_rdy[i] = 1'b1;
    for (int i = ARCH; i < PHYS; i++) m_free.push_back(i);
  endtask

  function automatic int arch_of(input int k);
    return int'(ren_arch[k*AW +: AW]);
  endfunction

  // One clock: predict from the model, advance the model, compare after the edge.
  task automatic run_cycle();
    int    exp_p [NSRC];
    bit    exp_r [NSRC];
    string tag_p [NSRC];
    bit    exp_v [L];
    int    exp_n [L];
    int    exp_o [L];
    string tag_o [L];
    string tag_v [L];
    int    nxt [ARCH];
    int    nreq;
    bit    g;
    int    used;
    bit    any_ret;
    nreq = 0;
    for (int k = 0; k < L; k++) nreq += int'(ren_req[k]);
    g = !restore_en && (nreq <= m_free.size());
    for (int s = 0; s < NSRC; s++) begin
      int a;
      a = int'(src_arch[s*AW +: AW]);
      exp_p[s] = m_map[a];
      exp_r[s] = m_rdy[exp_p[s]];
      for (int k = 0; k < L; k++)
        if (wb_en[k] && int'(wb_phys[k*PW +: PW]) == exp_p[s]) exp_r[s] = 1'b1;
      tag_p[s] = "R2";
      for (int k = 0; k < L; k++)
        if (g && ren_req[k] && arch_of(k) == a) tag_p[s] = "R6";
      if (force_tag != "") tag_p[s] = force_tag;
    end
    nxt = m_map;
    used = 0;
    for (int k = 0; k < L; k++) begin
      exp_v[k] = g && ren_req[k];
      tag_o[k] = "R4";
      tag_v[k] = restore_en ? "R8" : ((ren_req[k] && !g) ? "R7" : "R4");
      exp_n[k] = 0;
      exp_o[k] = 0;
      if (exp_v[k]) begin
        for (int j = 0; j < k; j++)
          if (exp_v[j] && arch_of(j) == arch_of(k)) tag_o[k] = "R5";
        exp_o[k] = nxt[arch_of(k)];
        exp_n[k] = m_free[used];
        used++;
        nxt[arch_of(k)] = exp_n[k];
      end
    end
    if (restore_en) nxt[int'(restore_arch)] = int'(restore_phys);
    for (int k = 0; k < L; k++) if (wb_en[k]) m_rdy[int'(wb_phys[k*PW +: PW])] = 1'b1;
    for (int k = 0; k < L; k++) if (exp_v[k]) m_rdy[exp_n[k]] = 1'b0;
    for (int k = 0; k < L; k++) if (exp_v[k]) m_pend.push_back(exp_o[k]);
    repeat (used) void'(m_free.pop_front());
    any_ret = 1'b0;
    for (int k = 0; k < L; k++)
      if (ret_en[k]) begin
        m_free.push_back(int'(ret_phys[k*PW +: PW]));
        any_ret = 1'b1;
      end
    m_map = nxt;
    @(negedge clk);
    for (int s = 0; s < NSRC; s++) begin
      chk(tag_p[s], "src_phys", int'(src_phys[s*PW +: PW]), exp_p[s]);
      chk(exp_r[s] ? (force_tag != "" ? force_tag : "R3") : "R10", "src_ready",
          int'(src_ready[s]), int'(exp_r[s]));
    end
    for (int k = 0; k < L; k++) begin
      chk(tag_v[k], "ren_valid", int'(ren_valid[k]), int'(exp_v[k]));
      if (exp_v[k]) begin
        chk("R4", "ren_new", int'(ren_new[k*PW +: PW]), exp_n[k]);
        chk(tag_o[k], "ren_old", int'(ren_old[k*PW +: PW]), exp_o[k]);
      end
    end
    chk(any_ret ? "R9" : "R11", "free_count", int'(free_count), m_free.size());
  endtask

  task automatic idle_inputs();
    ren_req = '0; restore_en = 1'b0; ret_en = '0; wb_en = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seed;
    seed = int'($urandom(32'd20241));
    model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "free_count after reset", int'(free_count), DEPTH);

    // R1: walk every architectural entry right after reset.
    force_tag = "R1";
    for (int grp = 0; grp < ARCH / NSRC; grp++) begin
      for (int s = 0; s < NSRC; s++) src_arch[s*AW +: AW] = AW'(grp*NSRC + s);
      run_cycle();
    end
    force_tag = "";

    // R5/R6: both lanes rename index 3, lookup of 3 in the same cycle.
    for (int s = 0; s < NSRC; s++) src_arch[s*AW +: AW] = 3'd3;
    ren_req = 2'b11;
    ren_arch = {3'd3, 3'd3};
    run_cycle();
    chk("R5", "lane1 old is lane0 new", int'(ren_old[PW +: PW]), int'(ren_new[0 +: PW]));
    idle_inputs();

    // R10: newest register for index 3 reads not ready, then racing writeback.
    run_cycle();
    chk("R10", "allocated reg not ready", int'(src_ready[0]), 0);
    wb_en = 2'b01;
    wb_phys = {4'd0, 4'(m_map[3])};
    run_cycle();
    chk("R3", "writeback bypass ready", int'(src_ready[0]), 1);
    wb_en = '0;
    run_cycle();

    // R8: rename index 5, then roll it back while lanes request.
    ren_req = 2'b01;
    ren_arch = {3'd0, 3'd5};
    run_cycle();
    begin
      int undo_new;
      int undo_old;
      undo_new = int'(ren_new[0 +: PW]);
      undo_old = int'(ren_old[0 +: PW]);
      void'(m_pend.pop_back());
      ren_req = 2'b11;
      ren_arch = {3'd1, 3'd2};
      restore_en = 1'b1;
      restore_arch = 3'd5;
      restore_phys = 4'(undo_old);
      ret_en = 2'b01;
      ret_phys = {4'd0, 4'(undo_new)};
      run_cycle();
      idle_inputs();
      for (int s = 0; s < NSRC; s++) src_arch[s*AW +: AW] = 3'd5;
      run_cycle();
      chk("R8", "restored entry", int'(src_phys[0 +: PW]), undo_old);
    end

    // R7: drain the pool, then request two lanes with fewer than two left.
    while (m_free.size() >= 2) begin
      ren_req = 2'b11;
      ren_arch = {3'(m_free.size() % ARCH), 3'(m_free.size() % 5)};
      run_cycle();
    end
    ren_req = 2'b11;
    ren_arch = {3'd6, 3'd7};
    run_cycle();
    chk("R7", "refused group count", int'(ren_valid), 0);
    idle_inputs();
    run_cycle();

    // Random phase with returns drained from the displaced list.
    for (int cyc = 0; cyc < 400; cyc++) begin
      idle_inputs();
      ren_req = L'($urandom % 4);
      ren_arch = (L*AW)'($urandom);
      src_arch = (NSRC*AW)'($urandom);
      for (int k = 0; k < L; k++) begin
        if (m_pend.size() > 0 && ($urandom % 3) != 0) begin
          ret_en[k] = 1'b1;
          ret_phys[k*PW +: PW] = 4'(m_pend.pop_front());
        end
        if (($urandom % 2) == 0) begin
          wb_en[k] = 1'b1;
          wb_phys[k*PW +: PW] = 4'($urandom % PHYS);
        end
      end
      run_cycle();
    end
    idle_inputs();
    run_cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule